// File: doc/BRIEF.md
# Page Translation Cache with Access-Rights Check

This block is a small, fully associative cache of page translations. It sits between address generation and the memory system. Each cycle it can take a 32-bit virtual address with an access kind (read or write) and the current privilege level. It answers in the same cycle with one of three outcomes. On a hit it returns the physical address. On a miss no valid entry holds the page. On a trap the page is present, but the access is not allowed.

The upper 20 bits of the virtual address select the page. The lower 12 bits pass through to the physical address unchanged. Each entry records its page tag, the 20-bit physical frame, and read, write, supervisor-only and dirty flags.

After a miss, an external page walker installs a complete entry through the refill port. The cache picks the slot itself. It reuses a slot that already holds the same page, otherwise it takes the lowest empty slot, otherwise it takes the slot under a rotating pointer. A single-cycle flush input empties the whole cache.

Top module: `xlat_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the stored 20-bit frame number in bits 31:12, and bits 11:0 are copied unchanged from `lk_vaddr[11:0]`. When there is no hit, `lk_paddr` and `lk_dirty` are zero.
- R2: A lookup (`lk_valid`=1) whose page number `lk_vaddr[31:12]` matches no valid entry raises `lk_miss`.
- R3: A lookup that matches a valid entry traps instead of hitting in two cases: a write (`lk_write`=1) to an entry without write permission, or a read (`lk_write`=0) to an entry without read permission.
- R4: A user-mode lookup (`lk_user`=1) that matches an entry marked supervisor-only traps. A supervisor-mode lookup (`lk_user`=0) to the same entry may hit.
- R5: `lk_hit`, `lk_miss` and `lk_trap` are never high together. All three are low while `lk_valid` is low. The result is combinational, in the cycle the address is presented.
- R6: A write lookup that hits sets the dirty flag of that entry from the next cycle on. `lk_dirty` reports the flag on later hits. A write that traps leaves the flag unchanged.
- R7: A refill becomes visible to lookups from the next cycle. A refill whose page number already sits in a valid entry overwrites that entry, so no page is ever held twice.
- R8: A refill of a new page takes the lowest-numbered invalid slot. When every slot is valid, it takes the slot under a rotating pointer, which starts at 0 after reset and advances by one (wrapping after 7) only on such replacements. A flush leaves the pointer unchanged.
- R9: `flush_all` invalidates every entry in one cycle. A refill requested in the same cycle is dropped.
- R10: In a cycle with `fill_valid` or `flush_all` high, the lookup is not served: hit, miss and trap are all low and no dirty flag changes.
- R11: After synchronous reset (`rst_n`=0 at a clock edge) every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address: page number 31:12, offset 11:0 |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No valid entry for this page |
| lk_trap | output | 1 | Entry found but access rights violated |
| lk_paddr | output | 32 | Physical address on hit, else zero |
| lk_dirty | output | 1 | Dirty flag of the hit entry, else zero |
| fill_valid | input | 1 | Install an entry at the next clock edge |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_ppn | input | 20 | Frame number of the new entry |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_sup | input | 1 | Supervisor-only page |
| fill_dirty | input | 1 | Initial dirty flag |
| flush_all | input | 1 | Invalidate all entries |

## Verification
A refill and a lookup can land in the same cycle, and so can a flush and a refill. These are the collisions that decide which state the next lookup sees. The bench drives a lookup while a refill is presented and expects all three outcome lines low. It also presents a flush with a refill and then expects a miss on the refilled page. Random traffic mixes refills, flushes and lookups over a small pool of pages, so these overlaps also arise without being steered. Every outcome is judged against a bench-side model of the slot contents and the rotating pointer.

// File: rtl/tlb_pkg.sv
// Package: shared widths and the stored entry layout of the translation cache.
// Assumes 4 KiB pages and 32-bit virtual and physical addresses.
package tlb_pkg;
    parameter int VPN_W = 20;
    parameter int PPN_W = 20;
    parameter int OFF_W = 12;
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PPN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             rd;
        logic             wr;
        logic             sup;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
// Module: tag comparator across all slots. Reports whether a valid slot holds
// the given page number and the index of that slot.
// Assumes at most one valid slot holds any page (refill dedup keeps this true).
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  tlb_entry_t [ENTRIES-1:0]    tbl,
    input  logic [VPN_W-1:0]            vpn,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);
    logic [ENTRIES-1:0] eq_vec;

    // Per-slot compare of tag and valid flag.
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign eq_vec[g] = tbl[g].valid && (tbl[g].vpn == vpn);
        end
    endgenerate

    // Encode the matching slot index.
    always_comb begin
        found = |eq_vec;
        idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq_vec[i]) idx = IDX_W'(i);
        end
    end

    AST_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq_vec)); // R7
endmodule

// File: rtl/tlb_victim.sv
// Module: slot chooser for refills. Reuses a slot that already holds the page,
// else the lowest empty slot, else the rotating pointer.
// Assumes fill_en is already gated by flush at the top.
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRIES-1:0]  valid_vec,
    input  logic                dup_hit,
    input  logic [IDX_W-1:0]    dup_idx,
    input  logic                fill_en,
    output logic [IDX_W-1:0]    victim_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    // Find the lowest-numbered invalid slot.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Pick the slot by priority: same page, empty, rotating.
    always_comb begin
        if (dup_hit)       victim_idx = dup_idx;
        else if (has_free) victim_idx = free_idx;
        else               victim_idx = rr_q;
    end

    // Advance the rotating pointer only when it was used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_en && !dup_hit && !has_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    AST_RR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q <= IDX_W'(ENTRIES - 1)); // R8
    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !dup_hit && has_free) |-> !valid_vec[victim_idx]); // R8
endmodule

// File: rtl/tlb_array.sv
// Module: entry storage. Handles reset, flush, refill writes and dirty marking.
// Assumes the caller never raises dirty_set in a refill or flush cycle.
module tlb_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_idx,
    input  tlb_entry_t                  fill_entry,
    input  logic                        dirty_set,
    input  logic [IDX_W-1:0]            dirty_idx,
    output tlb_entry_t [ENTRIES-1:0]    tbl,
    output logic [ENTRIES-1:0]          valid_vec
);
    tlb_entry_t [ENTRIES-1:0] tbl_q;

    // Update stored entries: reset, then flush, then refill or dirty mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i].valid <= 1'b0;
        end else begin
            if (fill_en)   tbl_q[fill_idx] <= fill_entry;
            if (dirty_set) tbl_q[dirty_idx].dirty <= 1'b1;
        end
    end

    // Expose the table and its valid flags.
    always_comb begin
        tbl = tbl_q;
        for (int i = 0; i < ENTRIES; i++) valid_vec[i] = tbl_q[i].valid;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0)); // R9
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> (tbl_q[$past(fill_idx)].valid
                                 && tbl_q[$past(fill_idx)].vpn == $past(fill_entry.vpn))); // R7
    AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_set && !flush) |=> tbl_q[$past(dirty_idx)].dirty); // R6
endmodule

// File: rtl/xlat_tlb.sv
// Module: top of the page translation cache. It gives a combinational lookup
// with a rights check and a one-cycle refill with slot choice.
// Assumes refill and flush take priority over a lookup in the same cycle.
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_trap,
    output logic [31:0]      lk_paddr,
    output logic             lk_dirty,
    input  logic             fill_valid,
    input  logic [19:0]      fill_vpn,
    input  logic [19:0]      fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_sup,
    input  logic             fill_dirty,
    input  logic             flush_all
);
    tlb_entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]       valid_vec;
    logic                     lk_found, dup_found;
    logic [IDX_W-1:0]         lk_idx, dup_idx, victim_idx;
    logic                     busy, serve, deny, fill_en, dirty_set;
    tlb_entry_t               sel, new_entry;
    logic [VPN_W-1:0]         lk_vpn;
    logic [OFF_W-1:0]         lk_off;

    // Split the virtual address into page number and offset.
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    // Build the entry to install from the refill port.
    always_comb begin
        new_entry       = '0;
        new_entry.valid = 1'b1;
        new_entry.dirty = fill_dirty;
        new_entry.rd    = fill_rd;
        new_entry.wr    = fill_wr;
        new_entry.sup   = fill_sup;
        new_entry.vpn   = fill_vpn;
        new_entry.ppn   = fill_ppn;
    end

    tlb_match #(.ENTRIES(ENTRIES)) lookup_cmp_i (
        .clk(clk), .rst_n(rst_n), .tbl(tbl), .vpn(lk_vpn),
        .found(lk_found), .idx(lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES)) fill_cmp_i (
        .clk(clk), .rst_n(rst_n), .tbl(tbl), .vpn(fill_vpn),
        .found(dup_found), .idx(dup_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
        .dup_hit(dup_found), .dup_idx(dup_idx), .fill_en(fill_en),
        .victim_idx(victim_idx)
    );

    tlb_array #(.ENTRIES(ENTRIES)) array_i (
        .clk(clk), .rst_n(rst_n), .flush(flush_all),
        .fill_en(fill_en), .fill_idx(victim_idx), .fill_entry(new_entry),
        .dirty_set(dirty_set), .dirty_idx(lk_idx),
        .tbl(tbl), .valid_vec(valid_vec)
    );

    // Resolve the lookup outcome and the rights check.
    always_comb begin
        busy     = fill_valid | flush_all;
        serve    = lk_valid & ~busy;
        sel      = tbl[lk_idx];
        deny     = (lk_write ? ~sel.wr : ~sel.rd) | (lk_user & sel.sup);
        lk_hit   = serve & lk_found & ~deny;
        lk_trap  = serve & lk_found & deny;
        lk_miss  = serve & ~lk_found;
        lk_paddr = lk_hit ? {sel.ppn, lk_off} : '0;
        lk_dirty = lk_hit & sel.dirty;
    end

    // Gate the state updates: flush beats refill, refill beats dirty marking.
    assign fill_en   = fill_valid & ~flush_all;
    assign dirty_set = lk_hit & lk_write;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_trap})); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_trap)); // R5
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R1
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || flush_all) |-> !(lk_hit || lk_miss || lk_trap)); // R10
    AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_user) |-> !sel.sup); // R4
    AST_WRITE_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write) |-> sel.wr); // R3
endmodule

// File: tb/xlat_tlb_tb.sv
// Bench: directed corner cases, then seeded random traffic, checked against a
// model of slots, rights, dirty flags and the rotating pointer.
module xlat_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, lk_user;
    logic [31:0] lk_vaddr;
    logic        lk_hit, lk_miss, lk_trap, lk_dirty;
    logic [31:0] lk_paddr;
    logic        fill_valid, fill_rd, fill_wr, fill_sup, fill_dirty, flush_all;
    logic [19:0] fill_vpn, fill_ppn;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit        m_v[8], m_d[8], m_r[8], m_w[8], m_s[8];
    bit [19:0] m_vpn[8], m_ppn[8];
    int        m_rr;

    always #10 clk = ~clk;

    xlat_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_trap(lk_trap), .lk_paddr(lk_paddr),
        .lk_dirty(lk_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .fill_sup(fill_sup), .fill_dirty(fill_dirty), .flush_all(flush_all)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_user = 0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_rd = 0; fill_wr = 0;
        fill_sup = 0; fill_dirty = 0; flush_all = 0;
    endtask

    function automatic int model_find(input bit [19:0] vpn);
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    // Inputs are set just after a falling edge; check mid-low-phase, then advance the model.
    task automatic step(input string req);
        int m, vi;
        bit serve, deny, e_hit, e_miss, e_trap, e_dirty;
        bit [31:0] e_pa;
        #5;
        serve = lk_valid && !fill_valid && !flush_all;
        m = model_find(lk_vaddr[31:12]);
        deny = 0;
        if (m >= 0) deny = (lk_write ? !m_w[m] : !m_r[m]) || (lk_user && m_s[m]);
        e_hit  = serve && m >= 0 && !deny;
        e_trap = serve && m >= 0 && deny;
        e_miss = serve && m < 0;
        e_pa   = e_hit ? {m_ppn[m], lk_vaddr[11:0]} : 32'h0;
        e_dirty = e_hit ? m_d[m] : 1'b0;
        chk({lk_hit, lk_miss, lk_trap} == {e_hit, e_miss, e_trap}, req,
            {lk_hit, lk_miss, lk_trap}, {e_hit, e_miss, e_trap});
        chk(lk_paddr == e_pa && lk_dirty == e_dirty, req,
            {lk_dirty, lk_paddr}, {e_dirty, e_pa});
        if (flush_all) begin
            for (int i = 0; i < 8; i++) m_v[i] = 0;
        end else if (fill_valid) begin
            vi = model_find(fill_vpn);
            if (vi < 0) begin
                for (int i = 7; i >= 0; i--) if (!m_v[i]) vi = i;
            end
            if (vi < 0) begin
                vi = m_rr;
                m_rr = (m_rr + 1) % 8;
            end
            m_v[vi] = 1; m_d[vi] = fill_dirty; m_r[vi] = fill_rd; m_w[vi] = fill_wr;
            m_s[vi] = fill_sup; m_vpn[vi] = fill_vpn; m_ppn[vi] = fill_ppn;
        end else if (e_hit && lk_write) begin
            m_d[m] = 1;
        end
    endtask

    task automatic fill(input bit [19:0] vpn, input bit [19:0] ppn, input bit rd,
                        input bit wr, input bit sup, input bit dty);
        @(negedge clk);
        drive_idle();
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
        fill_rd = rd; fill_wr = wr; fill_sup = sup; fill_dirty = dty;
        step("R7");
    endtask

    task automatic look(input bit [31:0] va, input bit wr, input bit usr,
                        input string req);
        @(negedge clk);
        drive_idle();
        lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_user = usr;
        step(req);
    endtask

    task automatic flush();
        @(negedge clk);
        drive_idle();
        flush_all = 1;
        step("R9");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        m_rr = 0;
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0; m_s[i] = 0;
            m_vpn[i] = 0; m_ppn[i] = 0;
        end
        drive_idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = 32'h1234_5678;
        #5;
        // R11 reset: outputs quiet while reset is held
        chk(!lk_hit && !lk_trap && lk_paddr == 0, "R11", {lk_hit, lk_trap}, 0);
        rst_n = 1;
        drive_idle();

        // R11 / R2: empty after reset
        look(32'h1234_5678, 0, 0, "R11");
        look(32'h0001_0000, 1, 1, "R2");

        // R1 / R7: install and translate
        fill(20'h00010, 20'hABCDE, 1, 1, 0, 0);
        look(32'h0001_0345, 0, 0, "R1");
        chk(lk_paddr == 32'hABCD_E345, "R1", lk_paddr, 32'hABCD_E345);
        look(32'h0001_0FFF, 0, 1, "R1");

        // R6: write hit sets dirty, seen on the next hit
        look(32'h0001_0010, 1, 0, "R6");
        look(32'h0001_0010, 0, 0, "R6");
        chk(lk_dirty == 1'b1, "R6", lk_dirty, 1);

        // R3: write to read-only page traps and leaves dirty clear
        fill(20'h00020, 20'h11111, 1, 0, 0, 0);
        look(32'h0002_0004, 1, 0, "R3");
        chk(lk_trap == 1'b1, "R3", lk_trap, 1);
        look(32'h0002_0004, 0, 0, "R6");
        chk(lk_hit && !lk_dirty, "R6", {lk_hit, lk_dirty}, 2'b10);

        // R3: read of a page without read permission traps
        fill(20'h00040, 20'h44444, 0, 1, 0, 0);
        look(32'h0004_0000, 0, 0, "R3");
        chk(lk_trap == 1'b1, "R3", lk_trap, 1);

        // R4: user access to supervisor page traps, supervisor hits
        fill(20'h00030, 20'h33333, 1, 1, 1, 0);
        look(32'h0003_0ABC, 0, 1, "R4");
        chk(lk_trap == 1'b1, "R4", lk_trap, 1);
        look(32'h0003_0ABC, 0, 0, "R4");
        chk(lk_hit == 1'b1, "R4", lk_hit, 1);

        // R10: lookup during refill is not served
        @(negedge clk);
        drive_idle();
        fill_valid = 1; fill_vpn = 20'h00050; fill_ppn = 20'h55555; fill_rd = 1;
        lk_valid = 1; lk_vaddr = 32'h0001_0000; lk_write = 1;
        step("R10");
        chk(!lk_hit && !lk_miss && !lk_trap, "R10", {lk_hit, lk_miss, lk_trap}, 0);

        // R7: refill of a held page overwrites it
        fill(20'h00010, 20'h77777, 1, 1, 0, 0);
        look(32'h0001_0123, 0, 0, "R7");
        chk(lk_paddr == 32'h7777_7123, "R7", lk_paddr, 32'h7777_7123);

        // R9: flush wins over a refill in the same cycle
        @(negedge clk);
        drive_idle();
        flush_all = 1; fill_valid = 1; fill_vpn = 20'h00060; fill_rd = 1;
        step("R9");
        look(32'h0006_0000, 0, 0, "R9");
        chk(lk_miss == 1'b1, "R9", lk_miss, 1);
        look(32'h0003_0000, 0, 0, "R9");

        // R8: fill all eight slots, then replace via rotating pointer
        for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h20000 + 20'(i), 1, 1, 0, 0);
        fill(20'h00108, 20'h20008, 1, 1, 0, 0);
        look(32'h0010_0000, 0, 0, "R8");
        chk(lk_miss == 1'b1, "R8", lk_miss, 1);
        fill(20'h00109, 20'h20009, 1, 1, 0, 0);
        look(32'h0010_1000, 0, 0, "R8");
        chk(lk_miss == 1'b1, "R8", lk_miss, 1);
        look(32'h0010_2000, 0, 0, "R8");
        chk(lk_hit == 1'b1, "R8", lk_hit, 1);

        // R5: random mix of lookups, refills and flushes
        for (int n = 0; n < 4000; n++) begin
            int sel;
            sel = $urandom % 40;
            @(negedge clk);
            drive_idle();
            if (sel == 0) begin
                flush_all = 1;
                fill_valid = $urandom % 2;
            end else if (sel < 10) begin
                fill_valid = 1;
            end
            fill_vpn = 20'h04000 + 20'($urandom % 12);
            fill_ppn = 20'($urandom);
            fill_rd = $urandom % 4 != 0; fill_wr = $urandom % 2; fill_sup = $urandom % 3 == 0;
            fill_dirty = $urandom % 4 == 0;
            lk_valid = $urandom % 8 != 0;
            lk_vaddr = {20'h04000 + 20'($urandom % 14), 12'($urandom)};
            lk_write = $urandom % 2; lk_user = $urandom % 2;
            step("R5");
        end

        @(negedge clk);
        drive_idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule